// File: doc/BRIEF.md
# Windowed Display-RAM Address Counter

This block produces the write address for a frame-buffer RAM that holds one bit per pixel. It keeps a horizontal position counted in bytes (X) and a vertical position counted in lines (Y). Both positions live inside a rectangular window. Each axis has its own start and end value. Every accepted RAM write moves the address one step. An entry-mode setting chooses the direction on each axis and which axis is the fast (primary) one. When the primary axis finishes its window it jumps back to its start and the other axis moves by one. When both finish, the address returns to the window origin.

A command decoder, which is outside this block, drives it through single-cycle load strobes: window bounds per axis, a direct preset per counter, and the entry mode. It also pulses a write strobe once for every data byte stored. The block presents the current X and Y positions and a flat RAM address. The flat address is formed as Y times the line length in bytes, plus X.

Top module: `win_addr_gen`

## Requirements
- R1: After reset, X and Y are 0, the X window is 0 to 18, the Y window is 0 to 211, the direction code is 11 and X is the primary axis.
- R2: With X primary and X counting up, each accepted write raises X by one while X differs from its window end, and Y is unchanged.
- R3: With X primary, a write when X equals its window end loads X with its window start and moves Y one step in its direction.
- R4: The 2-bit direction code sets the counting direction of each axis: bit 0 set makes X count up, bit 0 clear makes X count down, bit 1 does the same for Y.
- R5: With the axis select bit at 1, Y is primary: Y steps on each write, and when Y equals its window end it loads its window start and X moves one step.
- R6: A write that wraps both axes leaves the address at the window origin (X start, Y start).
- R7: An X preset writes X directly. A Y preset writes Y from an 8-bit low part and a high part holding bit 8. Neither preset changes a window bound.
- R8: Y window start and end are each built from an 8-bit low part and a high part, and a window load takes effect from the next write on.
- R9: A write strobe in the same cycle as any load strobe does not step either counter. Only the loaded value, if any, takes effect.
- R10: lin_addr always equals y_addr × 19 + x_addr, where 19 is the bytes-per-line parameter.
- R11: A counter that lies outside its window steps modulo 2^width in its direction until it equals its window end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| x_win_ld | input | 1 | Load X window bounds |
| x_win_start | input | 5 | X window start (bytes) |
| x_win_end | input | 5 | X window end (bytes) |
| y_win_ld | input | 1 | Load Y window bounds |
| y_win_start_lo | input | 8 | Y window start, low 8 bits |
| y_win_start_hi | input | 1 | Y window start, bit 8 |
| y_win_end_lo | input | 8 | Y window end, low 8 bits |
| y_win_end_hi | input | 1 | Y window end, bit 8 |
| x_set_ld | input | 1 | Preset X counter |
| x_set_val | input | 5 | X preset value |
| y_set_ld | input | 1 | Preset Y counter |
| y_set_lo | input | 8 | Y preset, low 8 bits |
| y_set_hi | input | 1 | Y preset, bit 8 |
| mode_ld | input | 1 | Load entry mode |
| mode_dir | input | 2 | Direction code: bit1 Y up, bit0 X up |
| mode_axis | input | 1 | Primary axis: 0 = X, 1 = Y |
| wr_stb | input | 1 | One RAM data byte written |
| x_addr | output | 5 | Current X position |
| y_addr | output | 9 | Current Y position |
| lin_addr | output | 14 | Flat RAM address |

## Verification
The bench targets the wrap points. A design with an off-by-one end compare would wrap a cycle late or early on an X window run that starts from reset. A design that dropped the secondary step would leave Y frozen after a wrap. Both decrement codes are run in windows whose start lies above their end, and there a design with swapped direction bits runs off the window instead of wrapping. Y-primary runs use a window above line 255, so a dropped ninth bit would show up there. Writes that coincide with load strobes, and counters preset outside their window, expose designs that step on a load or clamp to the window.

// File: rtl/win_addr_pkg.sv
package win_addr_pkg;

  // entry mode: direction of each axis and which axis is primary
  typedef struct packed {
    logic axis_y;  // 1: Y steps on every write
    logic y_up;    // direction code bit 1
    logic x_up;    // direction code bit 0
  } entry_mode_t;

  localparam entry_mode_t MODE_RST = '{axis_y: 1'b0, y_up: 1'b1, x_up: 1'b1};

endpackage

// File: rtl/entry_mode_reg.sv
module entry_mode_reg
  import win_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_ld,
  input  logic [1:0]  mode_dir,
  input  logic        mode_axis,
  output entry_mode_t mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
    end else if (mode_ld) begin
      mode_q.axis_y <= mode_axis;
      mode_q.y_up   <= mode_dir[1];
      mode_q.x_up   <= mode_dir[0];
    end
  end

endmodule

// File: rtl/addr_axis.sv
module addr_axis #(
  parameter int W         = 5,
  parameter int RST_START = 0,
  parameter int RST_END   = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         win_ld,
  input  logic [W-1:0] win_start_in,
  input  logic [W-1:0] win_end_in,
  input  logic         pre_ld,
  input  logic [W-1:0] pre_val,
  input  logic         step_en,
  input  logic         dir_up,
  output logic [W-1:0] cnt,
  output logic [W-1:0] win_start,
  output logic [W-1:0] win_end,
  output logic         at_end
);

  // one step in the chosen direction, modulo 2^W
  function automatic logic [W-1:0] next_pos(input logic [W-1:0] cur, input logic up);
    return up ? cur + 1'b1 : cur - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_start <= W'(RST_START);
      win_end   <= W'(RST_END);
    end else if (win_ld) begin
      win_start <= win_start_in;
      win_end   <= win_end_in;
    end
  end

  assign at_end = (cnt == win_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (pre_ld) begin
      cnt <= pre_val;
    end else if (step_en) begin
      cnt <= at_end ? win_start : next_pos(cnt, dir_up);
    end
  end

endmodule

// File: rtl/addr_linear.sv
module addr_linear #(
  parameter int XW  = 5,
  parameter int YW  = 9,
  parameter int BPL = 19,
  parameter int LW  = 14
) (
  input  logic [XW-1:0] x_in,
  input  logic [YW-1:0] y_in,
  output logic [LW-1:0] lin
);

  function automatic logic [LW-1:0] to_linear(input logic [YW-1:0] yy, input logic [XW-1:0] xx);
    return LW'(yy) * LW'(BPL) + LW'(xx);
  endfunction

  assign lin = to_linear(y_in, x_in);

endmodule

// File: rtl/win_addr_gen.sv
module win_addr_gen
  import win_addr_pkg::*;
#(
  parameter int XW             = 5,
  parameter int YW             = 9,
  parameter int BYTES_PER_LINE = 19,
  parameter int X_END_RST      = 18,
  parameter int Y_END_RST      = 211,
  localparam int YLO           = 8,
  localparam int YHI           = YW - YLO,
  localparam int LW            = $clog2((2**YW - 1) * BYTES_PER_LINE + 2**XW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           x_win_ld,
  input  logic [XW-1:0]  x_win_start,
  input  logic [XW-1:0]  x_win_end,
  input  logic           y_win_ld,
  input  logic [YLO-1:0] y_win_start_lo,
  input  logic [YHI-1:0] y_win_start_hi,
  input  logic [YLO-1:0] y_win_end_lo,
  input  logic [YHI-1:0] y_win_end_hi,
  input  logic           x_set_ld,
  input  logic [XW-1:0]  x_set_val,
  input  logic           y_set_ld,
  input  logic [YLO-1:0] y_set_lo,
  input  logic [YHI-1:0] y_set_hi,
  input  logic           mode_ld,
  input  logic [1:0]     mode_dir,
  input  logic           mode_axis,
  input  logic           wr_stb,
  output logic [XW-1:0]  x_addr,
  output logic [YW-1:0]  y_addr,
  output logic [LW-1:0]  lin_addr
);

  // named internal events, also used by the bound checker
  entry_mode_t   mode_q;
  logic          any_ld;
  logic          wr_go;
  logic          x_step;
  logic          y_step;
  logic          x_at_end;
  logic          y_at_end;
  logic [XW-1:0] x_ws;
  logic [XW-1:0] x_we;
  logic [YW-1:0] y_ws;
  logic [YW-1:0] y_we;

  assign any_ld = x_win_ld | y_win_ld | x_set_ld | y_set_ld | mode_ld;
  assign wr_go  = wr_stb & ~any_ld;

  // primary axis steps every write, secondary only when primary is at its end
  assign x_step = wr_go & (~mode_q.axis_y | y_at_end);
  assign y_step = wr_go & ( mode_q.axis_y | x_at_end);

  entry_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_ld   (mode_ld),
    .mode_dir  (mode_dir),
    .mode_axis (mode_axis),
    .mode_q    (mode_q)
  );

  addr_axis #(.W(XW), .RST_START(0), .RST_END(X_END_RST)) u_x (
    .clk          (clk),
    .rst_n        (rst_n),
    .win_ld       (x_win_ld),
    .win_start_in (x_win_start),
    .win_end_in   (x_win_end),
    .pre_ld       (x_set_ld),
    .pre_val      (x_set_val),
    .step_en      (x_step),
    .dir_up       (mode_q.x_up),
    .cnt          (x_addr),
    .win_start    (x_ws),
    .win_end      (x_we),
    .at_end       (x_at_end)
  );

  addr_axis #(.W(YW), .RST_START(0), .RST_END(Y_END_RST)) u_y (
    .clk          (clk),
    .rst_n        (rst_n),
    .win_ld       (y_win_ld),
    .win_start_in ({y_win_start_hi, y_win_start_lo}),
    .win_end_in   ({y_win_end_hi, y_win_end_lo}),
    .pre_ld       (y_set_ld),
    .pre_val      ({y_set_hi, y_set_lo}),
    .step_en      (y_step),
    .dir_up       (mode_q.y_up),
    .cnt          (y_addr),
    .win_start    (y_ws),
    .win_end      (y_we),
    .at_end       (y_at_end)
  );

  addr_linear #(.XW(XW), .YW(YW), .BPL(BYTES_PER_LINE), .LW(LW)) u_lin (
    .x_in (x_addr),
    .y_in (y_addr),
    .lin  (lin_addr)
  );

endmodule

// File: rtl/win_addr_chk.sv
module win_addr_chk #(
  parameter int XW = 5,
  parameter int YW = 9,
  parameter int LW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_stb,
  input logic          any_ld,
  input logic          x_set_ld,
  input logic          y_set_ld,
  input logic          axis_y,
  input logic          x_up,
  input logic [XW-1:0] x_addr,
  input logic [YW-1:0] y_addr,
  input logic [XW-1:0] x_ws,
  input logic [XW-1:0] x_we,
  input logic [YW-1:0] y_ws,
  input logic [YW-1:0] y_we,
  input logic [LW-1:0] lin_addr
);

  logic go;
  assign go = wr_stb & ~any_ld;

  // R9
  no_step_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && any_ld && !x_set_ld && !y_set_ld) |=> ($stable(x_addr) && $stable(y_addr)));

  // R2
  x_inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !axis_y && x_up && x_addr != x_we) |=> (x_addr == XW'($past(x_addr) + 1'b1)));

  // R4
  x_dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !axis_y && !x_up && x_addr != x_we) |=> (x_addr == XW'($past(x_addr) - 1'b1)));

  // R3
  x_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !axis_y && x_addr == x_we) |=> (x_addr == $past(x_ws)));

  // R2
  y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !axis_y && x_addr != x_we) |=> $stable(y_addr));

  // R5
  y_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && axis_y && y_addr == y_we) |=> (y_addr == $past(y_ws)));

  // R5
  x_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && axis_y && y_addr != y_we) |=> $stable(x_addr));

  // R10
  lin_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(x_addr) && $stable(y_addr)) |-> $stable(lin_addr));

endmodule

bind win_addr_gen win_addr_chk #(.XW(XW), .YW(YW), .LW(LW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_stb   (wr_stb),
  .any_ld   (any_ld),
  .x_set_ld (x_set_ld),
  .y_set_ld (y_set_ld),
  .axis_y   (mode_q.axis_y),
  .x_up     (mode_q.x_up),
  .x_addr   (x_addr),
  .y_addr   (y_addr),
  .x_ws     (x_ws),
  .x_we     (x_we),
  .y_ws     (y_ws),
  .y_we     (y_we),
  .lin_addr (lin_addr)
);

// File: tb/win_addr_gen_bench.sv
module win_addr_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       x_win_ld = 0, y_win_ld = 0, x_set_ld = 0, y_set_ld = 0, mode_ld = 0, wr_stb = 0;
  logic [4:0] x_win_start = 0, x_win_end = 0, x_set_val = 0;
  logic [7:0] y_win_start_lo = 0, y_win_end_lo = 0, y_set_lo = 0;
  logic       y_win_start_hi = 0, y_win_end_hi = 0, y_set_hi = 0;
  logic [1:0] mode_dir = 0;
  logic       mode_axis = 0;
  logic [4:0] x_addr;
  logic [8:0] y_addr;
  logic [13:0] lin_addr;

  always #2.5 clk = ~clk;

  win_addr_gen u_win_addr_gen (
    .clk(clk), .rst_n(rst_n),
    .x_win_ld(x_win_ld), .x_win_start(x_win_start), .x_win_end(x_win_end),
    .y_win_ld(y_win_ld), .y_win_start_lo(y_win_start_lo), .y_win_start_hi(y_win_start_hi),
    .y_win_end_lo(y_win_end_lo), .y_win_end_hi(y_win_end_hi),
    .x_set_ld(x_set_ld), .x_set_val(x_set_val),
    .y_set_ld(y_set_ld), .y_set_lo(y_set_lo), .y_set_hi(y_set_hi),
    .mode_ld(mode_ld), .mode_dir(mode_dir), .mode_axis(mode_axis),
    .wr_stb(wr_stb), .x_addr(x_addr), .y_addr(y_addr), .lin_addr(lin_addr)
  );

  typedef struct {
    int    ex;
    int    ey;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad = 0;
  bit   finished = 0;

  // bench-side reference state, taken from the requirements
  int m_x = 0, m_y = 0, m_xs = 0, m_xe = 18, m_ys = 0, m_ye = 211;
  bit m_xu = 1, m_yu = 1, m_ax = 0;

  function automatic int bump(int v, bit up, int modulus);
    if (up) return (v + 1) % modulus;
    return (v + modulus - 1) % modulus;
  endfunction

  function automatic void model_write();
    if (!m_ax) begin
      if (m_x == m_xe) begin
        m_x = m_xs;
        m_y = (m_y == m_ye) ? m_ys : bump(m_y, m_yu, 512);
      end else m_x = bump(m_x, m_xu, 32);
    end else begin
      if (m_y == m_ye) begin
        m_y = m_ys;
        m_x = (m_x == m_xe) ? m_xs : bump(m_x, m_xu, 32);
      end else m_y = bump(m_y, m_yu, 512);
    end
  endfunction

  function automatic void push(string tag);
    exp_t e;
    e.ex = m_x; e.ey = m_y; e.tag = tag;
    exp_q.push_back(e);
  endfunction

  task automatic clear_inputs();
    x_win_ld = 0; y_win_ld = 0; x_set_ld = 0; y_set_ld = 0; mode_ld = 0; wr_stb = 0;
  endtask

  task automatic drv_write(string tag);
    @(negedge clk);
    wr_stb = 1;
    model_write();
    if (m_x == m_xs && m_y == m_ys) push({tag, " R6"}); else push(tag);
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic drv_xwin(int s, int e, bit with_wr);
    @(negedge clk);
    x_win_ld = 1; x_win_start = 5'(s); x_win_end = 5'(e); wr_stb = with_wr;
    m_xs = s; m_xe = e;
    push(with_wr ? "R9" : "R8");
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic drv_ywin(int s, int e, bit with_wr);
    @(negedge clk);
    y_win_ld = 1; wr_stb = with_wr;
    y_win_start_lo = 8'(s); y_win_start_hi = s[8];
    y_win_end_lo = 8'(e); y_win_end_hi = e[8];
    m_ys = s; m_ye = e;
    push(with_wr ? "R9" : "R8");
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic drv_xset(int v, bit with_wr);
    @(negedge clk);
    x_set_ld = 1; x_set_val = 5'(v); wr_stb = with_wr;
    m_x = v;
    push(with_wr ? "R9" : "R7");
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic drv_yset(int v);
    @(negedge clk);
    y_set_ld = 1; y_set_lo = 8'(v); y_set_hi = v[8];
    m_y = v;
    push("R7");
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic drv_mode(int dir, bit ax, bit with_wr);
    @(negedge clk);
    mode_ld = 1; mode_dir = 2'(dir); mode_axis = ax; wr_stb = with_wr;
    m_xu = dir[0]; m_yu = dir[1]; m_ax = ax;
    push(with_wr ? "R9" : "R4");
    @(negedge clk);
    clear_inputs();
  endtask

  // monitor: pop one expected item per result cycle and compare
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        int   lin_exp;
        e = exp_q.pop_front();
        lin_exp = e.ey * 19 + e.ex;
        total++;
        if (int'(x_addr) != e.ex || int'(y_addr) != e.ey) begin
          bad++;
          $display("FAIL %s: addr x=%0d y=%0d expected x=%0d y=%0d", e.tag,
                   x_addr, y_addr, e.ex, e.ey);
        end else if (int'(lin_addr) != lin_exp) begin
          bad++;
          $display("FAIL R10: lin=%0d expected %0d", lin_addr, lin_exp);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    total++;
    if (x_addr != 0 || y_addr != 0 || lin_addr != 0) begin
      bad++;
      $display("FAIL R1: x=%0d y=%0d lin=%0d expected 0 0 0", x_addr, y_addr, lin_addr);
    end
    // R2 increment along X from reset
    for (int i = 0; i < 5; i++) drv_write("R2");
    for (int i = 0; i < 13; i++) drv_write("R2");
    // R1/R3 default X end of 18: wrap to start, Y steps up
    drv_write("R1 R3");
    drv_write("R2");
    // R7 presets, Y with ninth bit
    drv_xset(10, 0);
    drv_yset(261);
    drv_yset(2);
    // R9 writes coinciding with loads
    drv_xset(7, 1);
    drv_mode(3, 0, 1);
    drv_ywin(0, 211, 1);
    drv_xwin(0, 18, 1);
    // R4 both down, window start above end
    drv_mode(0, 0, 0);
    drv_xwin(5, 2, 0);
    drv_ywin(7, 3, 0);
    drv_xset(5, 0);
    drv_yset(7);
    for (int i = 0; i < 21; i++) drv_write("R4");
    // R4 Y down, X up
    drv_mode(1, 0, 0);
    drv_xwin(0, 1, 0);
    drv_ywin(1, 0, 0);
    drv_xset(0, 0);
    drv_yset(1);
    for (int i = 0; i < 5; i++) drv_write("R4");
    // R5/R8 Y primary, window above line 255
    drv_mode(3, 1, 0);
    drv_xwin(0, 3, 0);
    drv_ywin(256, 258, 0);
    drv_xset(0, 0);
    drv_yset(256);
    for (int i = 0; i < 13; i++) drv_write("R5 R8");
    // R5 with X down, Y up
    drv_mode(2, 1, 0);
    drv_xwin(3, 1, 0);
    drv_ywin(10, 11, 0);
    drv_xset(3, 0);
    drv_yset(10);
    for (int i = 0; i < 7; i++) drv_write("R5");
    // R11 counter outside window runs modulo 32 until it meets the end
    drv_mode(3, 0, 0);
    drv_xwin(0, 3, 0);
    drv_ywin(0, 5, 0);
    drv_yset(0);
    drv_xset(25, 0);
    for (int i = 0; i < 12; i++) drv_write("R11");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule